// File: doc/BRIEF.md
# Serial Configuration Register Bank for a Clock Generator

This block is the two-wire serial slave that holds the configuration bytes of a clock generator. It runs on a fast system clock and samples the bus clock and data lines as ordinary inputs. It pulls the data line low through an open-drain enable output. A host can reach the bank in two ways: it can address one byte by its offset, or it can stream through the bank from the first byte in block mode. Block reads start with a byte count.

Each stored bit appears on a parallel output bus, so the clock tree can use it directly. The bits cover per-output enables, a CPU spread enable and frequency and spread selection fields. Byte k of the bank sits on `cfgFlat[8k+7:8k]`, and bit 0 of byte 2 is also brought out on its own port. Every byte on the bus goes most significant bit first. The slave does not stretch the clock.

Top module: `smbcfg_bank`

## Requirements
- R1: When reset is released, the five bytes are 0: FFh, 1: FFh, 2: FEh, 3: 10h, 4: 00h, and byte k appears on cfgFlat bits 8k+7 down to 8k.
- R2: The slave acknowledges only the address bytes D2h (write) and D3h (read). After any other address it leaves the acknowledge slot high and ignores all traffic until the next start condition.
- R3: In the command byte, bit 7 = 1 selects single-byte access at the offset held in bits 4:0, and bit 7 = 0 selects block access starting at offset 0.
- R4: A command byte whose bits 6:5 are not 00 is not acknowledged, and no register changes until the next start.
- R5: A single-byte write (D2h, command, data, stop) stores the data byte at the offset given in the command.
- R6: A single-byte read (D2h, command, repeated start, D3h) returns the byte at that offset, most significant bit first.
- R7: In a block write (D2h, command, count, data...), the count byte is acknowledged but not used. The data bytes fill offsets 0, 1, 2 and so on, and a stop after any whole byte keeps the bytes already written.
- R8: A block read first returns the count 05h and then the bytes from offset 0 upward. It continues while the host acknowledges and stops sending after the host's NACK.
- R9: A write to an offset of 5 or above is acknowledged and discarded. A read from such an offset returns 00h.
- R10: The data-line enable changes only while the bus clock is low, and it is released after a stop condition.
- R11: Asserting reset in the middle of operation returns all five bytes to their R1 values.
- R12: cpuSpreadOn always equals bit 0 of byte 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset; loads the default bytes |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin (wired value) |
| sdaOe | output | 1 | 1 pulls the data line low |
| cfgFlat | output | 8*NUM_REGS (40) | All configuration bytes, byte k at bits 8k+7:8k |
| cpuSpreadOn | output | 1 | CPU spread enable, bit 0 of byte 2 |

## Verification
The bench targets the bank's edges. It writes and reads offsets 5 to 7: a design with a pointer that wraps or is unchecked would corrupt a real byte or return stale data. It checks that the block read sends a count of 5 ahead of byte 0, which a design that starts the data stream immediately would miss. It sends a foreign address and a non-zero chip-select field followed by data bytes: a slave that failed to go deaf after the NACK would store those bytes. Random single-byte writes and reads run against a bench model. A short block write stopped early and a reset in the middle of traffic catch pointer and default-value errors.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;
  // strobes from the bus controller to the register datapath
  typedef struct packed {
    logic shiftIn;    // capture one received bit
    logic setPtr;     // load pointer from command byte
    logic blockMode;  // with setPtr: start at offset 0
    logic ptrInc;     // advance pointer
    logic writeByte;  // store received byte at pointer
    logic loadCount;  // load transmit byte with bank size
    logic loadData;   // load transmit byte from pointer
    logic txShift;    // move to next transmit bit
  } strobe_t;
endpackage

// File: rtl/smbcfg_regs.sv
module smbcfg_regs
  import smbcfg_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter logic [8*NUM_REGS-1:0] RESET_VALS = 40'h00_10_FE_FF_FF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sdaBit,
  input  strobe_t               strb,
  output logic [7:0]            rxByte,
  output logic                  txBit,
  output logic [8*NUM_REGS-1:0] cfgFlat
);
  localparam int OFS_W = 5;

  logic [7:0]       rxShift;
  logic [7:0]       txReg;
  logic [OFS_W-1:0] ptr;
  logic [7:0]       rdByte;
  logic [7:0]       bank [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   bank[k] <= RESET_VALS[8*k +: 8];
      else if (strb.writeByte && ptr == OFS_W'(k)) bank[k] <= rxShift;
    end
    assign cfgFlat[8*k +: 8] = bank[k];
  end

  always_comb begin
    rdByte = 8'h00;
    for (int k = 0; k < NUM_REGS; k++)
      if (ptr == OFS_W'(k)) rdByte = bank[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= 8'h00;
      txReg   <= 8'hFF;
      ptr     <= '0;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[6:0], sdaBit};
      if (strb.setPtr)  ptr <= strb.blockMode ? '0 : rxShift[OFS_W-1:0];
      else if (strb.ptrInc) ptr <= ptr + 1'b1;
      if (strb.loadCount)     txReg <= 8'(NUM_REGS);
      else if (strb.loadData) txReg <= rdByte;
      else if (strb.txShift)  txReg <= {txReg[6:0], 1'b0};
    end
  end

  assign rxByte = rxShift;
  assign txBit  = txReg[7];
endmodule

// File: rtl/smbcfg_ctrl.sv
module smbcfg_ctrl
  import smbcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output strobe_t    strb,
  output logic       sdaBit,
  output logic       sdaOe
);
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK, ST_DEAF} state_t;
  typedef enum logic [1:0] {RL_ADDR, RL_CMD, RL_COUNT, RL_DATA} role_t;

  logic [1:0] sclSync, sdaSync;
  logic       sclQ, sdaQ;
  logic       sclS, sdaS, sclRise, sclFall, busStart, busStop;

  state_t     st, stN;
  role_t      role, roleN;
  logic [3:0] bitCnt, bitN;
  logic       readDir, readN, blockSel, blockN, txFirst, txFirstN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11; sdaSync <= 2'b11; sclQ <= 1'b1; sdaQ <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclQ    <= sclSync[1];
      sdaQ    <= sdaSync[1];
    end
  end

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign busStart = sclS & sclQ & sdaQ & ~sdaS;
  assign busStop  = sclS & sclQ & ~sdaQ & sdaS;
  assign sdaBit   = sdaS;

  always_comb begin
    stN = st; roleN = role; bitN = bitCnt;
    readN = readDir; blockN = blockSel; txFirstN = txFirst;
    strb = '0;
    if (busStart) begin
      stN = ST_RX; roleN = RL_ADDR; bitN = 4'd0; readN = 1'b0;
    end else if (busStop) begin
      stN = ST_IDLE;
    end else begin
      unique case (st)
        ST_RX: begin
          if (sclRise && bitCnt < 4'd8) begin
            strb.shiftIn = 1'b1;
            bitN = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            stN = ST_RXACK;
            unique case (role)
              RL_ADDR: begin
                if (rxByte[7:1] != DEV_ADDR) stN = ST_DEAF;
                else begin
                  readN = rxByte[0];
                  roleN = RL_CMD;
                end
              end
              RL_CMD: begin
                if (rxByte[6:5] != 2'b00) stN = ST_DEAF;
                else begin
                  strb.setPtr    = 1'b1;
                  strb.blockMode = ~rxByte[7];
                  blockN         = ~rxByte[7];
                  roleN          = rxByte[7] ? RL_DATA : RL_COUNT;
                end
              end
              RL_COUNT: roleN = RL_DATA;
              default: begin
                strb.writeByte = 1'b1;
                strb.ptrInc    = 1'b1;
              end
            endcase
          end
        end
        ST_RXACK: begin
          if (sclFall) begin
            bitN = 4'd0;
            if (readDir) begin
              stN = ST_TX;
              txFirstN = blockSel;
              if (blockSel) strb.loadCount = 1'b1;
              else          strb.loadData  = 1'b1;
            end else begin
              stN = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclRise) bitN = bitCnt + 4'd1;
          else if (sclFall) begin
            if (bitCnt == 4'd8) stN = ST_TXACK;
            else                strb.txShift = 1'b1;
          end
        end
        ST_TXACK: begin
          if (sclRise) begin
            if (sdaS)          stN = ST_DEAF;
            else if (!txFirst) strb.ptrInc = 1'b1;
          end else if (sclFall) begin
            stN = ST_TX; bitN = 4'd0; txFirstN = 1'b0;
            strb.loadData = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE; role <= RL_ADDR; bitCnt <= 4'd0;
      readDir <= 1'b0; blockSel <= 1'b0; txFirst <= 1'b0;
    end else begin
      st <= stN; role <= roleN; bitCnt <= bitN;
      readDir <= readN; blockSel <= blockN; txFirst <= txFirstN;
    end
  end

  assign sdaOe = (st == ST_RXACK) || (st == ST_TX && !txBit);
endmodule

// File: rtl/smbcfg_bank.sv
module smbcfg_bank
  import smbcfg_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [8*NUM_REGS-1:0] RESET_VALS = 40'h00_10_FE_FF_FF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [8*NUM_REGS-1:0] cfgFlat,
  output logic                  cpuSpreadOn
);
  localparam int SPREAD_BIT = 16;

  strobe_t    strb;
  logic [7:0] rxByte;
  logic       txBit, sdaBit;

  smbcfg_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txBit(txBit), .strb(strb), .sdaBit(sdaBit), .sdaOe(sdaOe)
  );

  smbcfg_regs #(.NUM_REGS(NUM_REGS), .RESET_VALS(RESET_VALS)) u_regs (
    .clk(clk), .rstN(rstN), .sdaBit(sdaBit), .strb(strb),
    .rxByte(rxByte), .txBit(txBit), .cfgFlat(cfgFlat)
  );

  assign cpuSpreadOn = cfgFlat[SPREAD_BIT];
endmodule

// File: rtl/smbcfg_checks.sv
module smbcfg_checks
  import smbcfg_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter logic [8*NUM_REGS-1:0] RESET_VALS = 40'h00_10_FE_FF_FF
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaIn,
  input logic                  sdaOe,
  input logic [8*NUM_REGS-1:0] cfgFlat,
  input strobe_t               strb
);
  // independent view of a stop condition seen at the pins
  logic [2:0] sclP, sdaP;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin sclP <= 3'b111; sdaP <= 3'b111; end
    else begin sclP <= {sclP[1:0], sclIn}; sdaP <= {sdaP[1:0], sdaIn}; end
  end
  logic pinStop;
  assign pinStop = sclP[2] & sclP[1] & ~sdaP[2] & sdaP[1];

  p_reset_defaults_r1: assert property (@(posedge clk)
    !rstN |=> cfgFlat == RESET_VALS);

  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    pinStop |-> ##2 !sdaOe);

  p_write_scl_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgFlat) |-> !sclIn);

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftIn, strb.setPtr, strb.writeByte, strb.loadCount,
              strb.loadData, strb.txShift}));
endmodule

bind smbcfg_bank smbcfg_checks #(.NUM_REGS(NUM_REGS), .RESET_VALS(RESET_VALS)) u_checks (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaOe(sdaOe),
  .cfgFlat(cfgFlat), .strb(strb)
);

// File: tb/smbcfg_bank_test.sv
module smbcfg_bank_test;
  localparam int H = 12;
  localparam logic [39:0] DEFS = 40'h00_10_FE_FF_FF;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, sclM, sdaM, sdaOe, cpuSpreadOn;
  logic [39:0] cfgFlat;
  wire sdaLine;
  assign sdaLine = sdaM & ~sdaOe;

  smbcfg_bank uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .cfgFlat(cfgFlat), .cpuSpreadOn(cpuSpreadOn)
  );

  int checks = 0, fails = 0, sclViol = 0;
  logic [7:0] model [5];
  logic prevOe = 1'b0;

  always @(negedge clk) begin
    if (rstN && sclM && sdaOe != prevOe) sclViol++;
    prevOe <= sdaOe;
  end

  function automatic logic [39:0] flatOf();
    logic [39:0] f;
    for (int k = 0; k < 5; k++) f[8*k +: 8] = model[k];
    return f;
  endfunction

  function automatic logic [7:0] expRead(input int ofs);
    return (ofs < 5) ? model[ofs] : 8'h00;
  endfunction

  task automatic modelReset();
    for (int k = 0; k < 5; k++) model[k] = DEFS[8*k +: 8];
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitc(H); sclM = 1'b1; waitc(H);
    sdaM = 1'b0; waitc(H); sclM = 1'b0; waitc(2);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitc(H); sclM = 1'b1; waitc(H);
    sdaM = 1'b1; waitc(H);
  endtask

  task automatic bitOut(input logic b);
    sdaM = b; waitc(H); sclM = 1'b1; waitc(H); sclM = 1'b0; waitc(2);
  endtask

  task automatic bitIn(output logic b);
    sdaM = 1'b1; waitc(H); sclM = 1'b1; waitc(H/2);
    b = sdaLine; waitc(H/2); sclM = 1'b0; waitc(2);
  endtask

  task automatic sendByte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) bitOut(d[i]);
    bitIn(b);
    ack = !b;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bitIn(b); d[i] = b; end
    bitOut(!giveAck);
  endtask

  task automatic byteWrite(input logic [7:0] ofs, input logic [7:0] d, output bit allAck);
    bit a0, a1, a2;
    startCond(); sendByte(8'hD2, a0); sendByte(8'h80 | ofs, a1); sendByte(d, a2); stopCond();
    allAck = a0 & a1 & a2;
    if (ofs < 5) model[ofs] = d;
  endtask

  task automatic byteRead(input logic [7:0] ofs, output logic [7:0] d, output bit allAck);
    bit a0, a1, a2;
    startCond(); sendByte(8'hD2, a0); sendByte(8'h80 | ofs, a1);
    startCond(); sendByte(8'hD3, a2); recvByte(1'b0, d); stopCond();
    allAck = a0 & a1 & a2;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    bit a0, a1, a2, a3;
    logic [7:0] d;
    void'($urandom(32'h5EED1234));
    rstN = 1'b0; sclM = 1'b1; sdaM = 1'b1;
    modelReset();
    waitc(10); rstN = 1'b1; waitc(10);

    // R1, R12: reset values
    check(cfgFlat == DEFS, "R1 defaults", cfgFlat, DEFS);
    check(cpuSpreadOn == 1'b0, "R12 spread off", cpuSpreadOn, 0);

    // R5, R3: byte write at offset 3
    byteWrite(8'd3, 8'hA5, ok);
    check(ok, "R5 write acks", ok, 1);
    check(cfgFlat == flatOf(), "R5 R3 byte write offset 3", cfgFlat, flatOf());

    // R6: byte read back
    byteRead(8'd3, d, ok);
    check(ok && d == 8'hA5, "R6 byte read offset 3", d, 8'hA5);

    // R2: foreign address ignored
    startCond(); sendByte(8'hA0, a0); sendByte(8'h81, a1); sendByte(8'h00, a2); stopCond();
    check(!a0, "R2 foreign address nack", a0, 0);
    check(!a1 && !a2 && cfgFlat == flatOf(), "R2 traffic ignored", cfgFlat, flatOf());

    // R4: chip-select field non-zero
    startCond(); sendByte(8'hD2, a0); sendByte(8'hA1, a1); sendByte(8'h00, a2); stopCond();
    check(a0 && !a1, "R4 chip select nack", a1, 0);
    check(!a2 && cfgFlat == flatOf(), "R4 no write", cfgFlat, flatOf());

    // R7: block write of 3 bytes then stop
    startCond(); sendByte(8'hD2, a0); sendByte(8'h00, a1); sendByte(8'h09, a2); sendByte(8'h3C, a3);
    ok = a0 & a1 & a2 & a3;
    sendByte(8'h5A, a3); ok &= a3;
    sendByte(8'h11, a3); ok &= a3;
    stopCond();
    model[0] = 8'h3C; model[1] = 8'h5A; model[2] = 8'h11;
    check(ok, "R7 block write acks", ok, 1);
    check(cfgFlat == flatOf(), "R7 block write early stop", cfgFlat, flatOf());
    check(cpuSpreadOn == model[2][0], "R12 spread follows byte 2", cpuSpreadOn, model[2][0]);

    // R8: block read
    startCond(); sendByte(8'hD2, a0); sendByte(8'h00, a1);
    startCond(); sendByte(8'hD3, a2);
    recvByte(1'b1, d);
    check(a0 && a1 && a2 && d == 8'h05, "R8 block read count", d, 8'h05);
    for (int k = 0; k < 5; k++) begin
      recvByte(k != 4, d);
      check(d == model[k], "R8 block read data", d, model[k]);
    end
    stopCond();
    check(sdaOe == 1'b0, "R10 released after stop", sdaOe, 0);

    // R9: offsets beyond the bank
    byteWrite(8'd7, 8'h77, ok);
    check(ok && cfgFlat == flatOf(), "R9 out of range write discarded", cfgFlat, flatOf());
    byteRead(8'd5, d, ok);
    check(ok && d == 8'h00, "R9 out of range read", d, 8'h00);

    // R12: set spread bit
    byteWrite(8'd2, 8'h01, ok);
    check(cpuSpreadOn == 1'b1, "R12 spread on", cpuSpreadOn, 1);

    // R5, R6: random traffic
    for (int n = 0; n < 40; n++) begin
      int ofs;
      logic [7:0] v;
      ofs = int'($urandom_range(0, 7));
      v = 8'($urandom);
      if ($urandom_range(0, 1) == 0) begin
        byteWrite(8'(ofs), v, ok);
        check(ok && cfgFlat == flatOf(), "R5 random write", cfgFlat, flatOf());
      end else begin
        byteRead(8'(ofs), d, ok);
        check(ok && d == expRead(ofs), "R6 random read", d, expRead(ofs));
      end
    end

    check(sclViol == 0, "R10 sda enable changes only with scl low", sclViol, 0);

    // R11: reset during operation
    byteWrite(8'd4, 8'hC3, ok);
    waitc(5); rstN = 1'b0; waitc(4);
    check(cfgFlat == DEFS, "R11 reset restores defaults", cfgFlat, DEFS);
    rstN = 1'b1; modelReset(); waitc(10);
    byteRead(8'd2, d, ok);
    check(ok && d == 8'hFE, "R11 R1 readback after reset", d, 8'hFE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule